// File: doc/BRIEF.md
# Periodic Countdown Interrupt Timer Channel

This block is one countdown timer channel with a small register interface. Software stores a start value, switches the channel on, and the channel counts down once per clock. When the count reaches zero, the channel emits a single-cycle trigger pulse, latches a timeout flag and reloads the start value. An interrupt request output follows the timeout flag whenever interrupts are unmasked.

The interface is a plain synchronous register port: a two-bit address, a write strobe with write data, and combinational read data. A new start value written while the channel runs does not disturb the count in progress. It takes effect at the next reload. To restart a period from the stored value, software clears the run bit and then sets it again. The timeout flag stays set until software writes a one to it, so a pending interrupt is never lost and never re-raised while it is still pending.

Top module: `countdown_timer`

## Requirements
- R1: After reset, every register reads 0, and `irqOut` and `trigOut` are 0.
- R2: Register map by `regAddr`: 0 = start value (read/write, full width); 1 = current count (read-only, writes are ignored); 2 = control, where bit 0 is run and bit 1 is interrupt enable, and all other bits read 0; 3 = flag, where bit 0 is the timeout flag and all other bits read 0.
- R3: A write that changes the run bit from 0 to 1 makes the count equal to the stored start value in the next cycle. After that, the count falls by one each clock.
- R4: While running with a count of 0, `trigOut` is 1 for that cycle, and in the next cycle the count equals the start value. With a nonzero start value N, the trigger is a one-cycle pulse every N+1 cycles.
- R5: The timeout flag is set by every trigger. Writing 1 to flag bit 0 clears it, writing 0 leaves it unchanged, and it stays set through later timeouts until it is cleared.
- R6: If a trigger and a flag-clear write fall in the same cycle, the flag ends up 1.
- R7: While the run bit is 0, the count holds its value and `trigOut` stays 0. Flag-clear writes are still accepted.
- R8: Writing the start value while running leaves the current count sequence unchanged. The new value appears in the count at the reload after the next trigger.
- R9: Clearing and then setting the run bit restarts the count from the stored start value.
- R10: `irqOut` is 1 exactly when the timeout flag and the interrupt enable bit are both 1.
- R11: With a start value of 0 and the run bit set, `trigOut` is 1 on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register select |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | CNT_W | Write data |
| regRdData | output | CNT_W | Combinational read data of the selected register |
| irqOut | output | 1 | Masked interrupt request |
| trigOut | output | 1 | Single-cycle trigger at each timeout |

## Verification
Some checks run on every cycle. These cover the count's next value after a start, a reload or a decrement, the count holding while stopped, the flag being set by a trigger and staying set unless cleared, the set-over-clear priority, and the trigger being a single pulse for nonzero start values. Other behaviour can only be shown by the bench's scenarios: deferred start-value updates across a reload, the off/on restart, interrupt masking as seen at the port, the read-only count and the zero upper bits, and the back-to-back triggers with a zero start value. The bench also runs long random register traffic against its own reference model.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_FLAG  = 2'd3
  } regSel_e;

  localparam int RUN_BIT = 0;
  localparam int IEN_BIT = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic start;      // run bit rising: load start value
    logic reload;     // timeout: load start value
    logic decrement;  // running, count nonzero
    logic startWrite; // software writes start value
  } tmrStrobe_t;

endpackage

// File: rtl/timer_dp.sv
module timer_dp
  import timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] startVal,
  output logic [CNT_W-1:0] count,
  output logic             cntZero
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startVal <= '0;
    end else if (strobe.startWrite) begin
      startVal <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.start || strobe.reload) begin
      count <= startVal;
    end else if (strobe.decrement) begin
      count <= count - ONE;
    end
  end

  assign cntZero = (count == '0);

  p_start_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> count == $past(startVal));

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decrement |=> count == $past(count) - ONE);

  p_reload_value_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> count == $past(startVal));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.start || strobe.reload || strobe.decrement) |=> $stable(count));

endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic [1:0] wrBits,
  input  logic       cntZero,
  output tmrStrobe_t strobe,
  output logic       runEn,
  output logic       irqEn,
  output logic       flag,
  output logic       trig,
  output logic       irq
);

  logic ctrlWrite;
  logic clearWrite;

  assign ctrlWrite  = regWrEn && (regSel_e'(regAddr) == SEL_CTRL);
  assign clearWrite = regWrEn && (regSel_e'(regAddr) == SEL_FLAG) && wrBits[0];
  assign trig       = runEn && cntZero;
  assign irq        = flag && irqEn;

  always_comb begin
    strobe            = '0;
    strobe.start      = ctrlWrite && wrBits[RUN_BIT] && !runEn;
    strobe.reload     = trig;
    strobe.decrement  = runEn && !cntZero;
    strobe.startWrite = regWrEn && (regSel_e'(regAddr) == SEL_START);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn <= 1'b0;
      irqEn <= 1'b0;
    end else if (ctrlWrite) begin
      runEn <= wrBits[RUN_BIT];
      irqEn <= wrBits[IEN_BIT];
    end
  end

  // set has priority over software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag <= 1'b0;
    end else if (trig) begin
      flag <= 1'b1;
    end else if (clearWrite) begin
      flag <= 1'b0;
    end
  end

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    trig |=> flag);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    flag && !clearWrite |=> flag);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    trig && clearWrite |=> flag);

  p_start_runs_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> runEn);

endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  output logic             irqOut,
  output logic             trigOut
);

  tmrStrobe_t       strobe;
  logic [CNT_W-1:0] startVal;
  logic [CNT_W-1:0] count;
  logic             cntZero;
  logic             runEn;
  logic             irqEn;
  logic             flag;

  timer_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .wrBits  (regWrData[1:0]),
    .cntZero (cntZero),
    .strobe  (strobe),
    .runEn   (runEn),
    .irqEn   (irqEn),
    .flag    (flag),
    .trig    (trigOut),
    .irq     (irqOut)
  );

  timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWrData),
    .startVal (startVal),
    .count    (count),
    .cntZero  (cntZero)
  );

  always_comb begin
    regRdData = '0;
    unique case (regSel_e'(regAddr))
      SEL_START: regRdData = startVal;
      SEL_COUNT: regRdData = count;
      SEL_CTRL: begin
        regRdData[RUN_BIT] = runEn;
        regRdData[IEN_BIT] = irqEn;
      end
      SEL_FLAG:  regRdData[0] = flag;
      default:   regRdData = '0;
    endcase
  end

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    trigOut && (startVal != '0) && !strobe.startWrite |=> !trigOut);

endmodule

// File: tb/countdown_timer_bench.sv
`timescale 1ns/1ps
module countdown_timer_bench;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   regAddr = '0;
  logic         regWrEn = 1'b0;
  logic [W-1:0] regWrData = '0;
  logic [W-1:0] regRdData;
  logic         irqOut;
  logic         trigOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  countdown_timer #(.CNT_W(W)) u_countdown_timer (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqOut    (irqOut),
    .trigOut   (trigOut)
  );

  // reference model built from the requirements
  logic [W-1:0] mStart, mCnt;
  logic         mRun, mIen, mFlag;

  always @(posedge clk or negedge rstN) begin
    logic t;
    if (!rstN) begin
      mStart = '0; mCnt = '0; mRun = 0; mIen = 0; mFlag = 0;
    end else begin
      t = mRun && (mCnt == 0);
      if (regWrEn && regAddr == 2 && regWrData[0] && !mRun) mCnt = mStart;
      else if (t) mCnt = mStart;
      else if (mRun) mCnt = mCnt - 1;
      if (t) mFlag = 1;
      else if (regWrEn && regAddr == 3 && regWrData[0]) mFlag = 0;
      if (regWrEn && regAddr == 0) mStart = regWrData;
      if (regWrEn && regAddr == 2) begin mRun = regWrData[0]; mIen = regWrData[1]; end
    end
  end

  function automatic logic [W-1:0] expRead(logic [1:0] a);
    case (a)
      2'd0: return mStart;
      2'd1: return mCnt;
      2'd2: return {30'd0, mIen, mRun};
      default: return {31'd0, mFlag};
    endcase
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    cyc();
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [W-1:0] v);
    regAddr = a; #1; v = regRdData;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] c0;
    void'($urandom(32'd1234));
    repeat (3) cyc();
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a[1:0], v); chk("R1 reset read", v, 0); end
    chk("R1 reset irq", irqOut, 0);
    chk("R1 reset trig", trigOut, 0);
    rstN = 1'b1;
    cyc();

    // R2 map: count is read-only, unused bits read 0
    wr(1, 32'h55);
    rd(1, v); chk("R2 count read-only", v, 0);
    wr(0, 32'hDEAD_BEEF);
    rd(0, v); chk("R2 start readback", v, 32'hDEAD_BEEF);
    wr(2, 32'hFFFF_FFFC);
    rd(2, v); chk("R2 ctrl unused bits", v, 0);

    // R3 start and count down
    wr(0, 5);
    wr(2, 1);
    rd(1, v); chk("R3 load on enable", v, 5);
    cyc(); rd(1, v); chk("R3 decrement", v, 4);
    repeat (4) cyc();
    rd(1, v); chk("R4 count zero", v, 0);
    chk("R4 trigger at zero", trigOut, 1);
    cyc(); rd(1, v); chk("R4 reload value", v, 5);
    chk("R4 single pulse", trigOut, 0);
    rd(3, v); chk("R5 flag set", v, 1);
    chk("R10 masked irq", irqOut, 0);

    // R5 write 0 ignored, R10 irq on enable
    wr(3, 0);
    rd(3, v); chk("R5 write zero no effect", v, 1);
    wr(2, 3);
    chk("R10 irq raised", irqOut, 1);
    rd(2, v); chk("R2 ctrl readback", v, 3);
    wr(3, 1);
    rd(3, v); chk("R5 flag cleared", v, 0);
    chk("R10 irq dropped", irqOut, 0);

    // R8 deferred start value
    rd(1, c0);
    wr(0, 9);
    rd(1, v); chk("R8 count undisturbed", v, (c0 == 0) ? 5 : c0 - 1);
    while (trigOut !== 1'b1) cyc();
    cyc(); rd(1, v); chk("R8 new value at reload", v, 9);

    // R7 hold while stopped, R9 restart
    repeat (3) cyc();
    wr(2, 2);
    rd(1, c0);
    repeat (3) cyc();
    rd(1, v); chk("R7 count holds", v, c0);
    chk("R7 no trigger", trigOut, 0);
    rd(3, v);
    if (v[0]) begin wr(3, 1); rd(3, v); chk("R7 clear while stopped", v, 0); end
    wr(2, 3);
    rd(1, v); chk("R9 restart from start value", v, 9);

    // R6 set beats clear
    while (trigOut !== 1'b1) cyc();
    wr(3, 1);
    rd(3, v); chk("R6 set wins", v, 1);

    // R11 zero start value
    wr(0, 0);
    wr(2, 0);
    wr(2, 1);
    for (int i = 0; i < 4; i++) begin chk("R11 trigger every cycle", trigOut, 1); cyc(); end

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom % 10;
      if (r < 3) begin
        logic [1:0] a = 2'($urandom % 4);
        logic [W-1:0] d = (a == 0) ? W'($urandom % 8) : W'($urandom);
        wr(a, d);
      end else begin
        cyc();
      end
      chk("R4 random trigger", trigOut, mRun && mCnt == 0);
      chk("R10 random irq", irqOut, mFlag && mIen);
      regAddr = 2'($urandom % 4); #1;
      chk("R2 random readback", regRdData, expRead(regAddr));
    end
    finishRun();
  end

endmodule